// File: doc/BRIEF.md
# Expansion ROM Identifier Patcher

This block sits beside a byte-wide synchronous RAM that holds an expansion ROM image and, when told to, makes the identifiers stored inside the image agree with the identifiers the device is configured with. After a start pulse it reads the image header and checks the signature word. It then follows the header's pointer to the identifier structure and checks that structure's four-byte tag. If the stored vendor or device identifier differs from the configured value, the block overwrites it and corrects the image checksum byte, so the 8-bit sum of the whole image does not change.

The correction is incremental. For each replaced identifier, the old identifier's two bytes are added to the checksum byte and the new identifier's two bytes are subtracted from it. No pass over the full image is needed. A control input turns patching off, for example when the image is not the device's default one. A one-cycle done pulse ends every run, and a 2-bit code tells which validity check, if any, stopped the run.

Top module: `romid_fixup`

## Requirements
- R1: While reset is held and right after it, `done` and `mem_we` are low and `err_code` is 0.
- R2: The signature is byte 0 = 0x55 and byte 1 = 0xAA. Any other value ends the run with `err_code` = 1 and no memory write.
- R3: The structure pointer is the little-endian word at bytes 0x18 (low) and 0x19 (high). If pointer + 8 is not below `ROM_BYTES`, the run ends with `err_code` = 2 and no write. A pointer of `ROM_BYTES` - 9 is accepted.
- R4: The bytes at pointer+0..3 must be 0x50, 0x43, 0x49, 0x52 in that order. Otherwise the run ends with `err_code` = 3 and no write.
- R5: The vendor identifier is little-endian at pointer+4/+5 and the device identifier at pointer+6/+7. An identifier that differs from `vid_cfg` or `did_cfg` is replaced by the configured value. An identifier that matches is not written.
- R6: The checksum is the byte at offset 6. For each replaced identifier it gains the old low and high bytes and loses the new low and high bytes, modulo 256. Both corrections accumulate, so the 8-bit sum of all image bytes is unchanged.
- R7: When both identifiers already match, the run ends with `err_code` = 0 and no memory write at all.
- R8: A start with `patch_en` low ends with `err_code` = 0 and no memory write.
- R9: Every start accepted while idle produces exactly one single-cycle `done` pulse. `err_code` is valid with that pulse and held until the next start.
- R10: No image byte other than offset 6 and pointer+4..+7 is ever written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a run when the block is idle |
| patch_en | input | 1 | High allows patching; low makes a run finish with no access |
| vid_cfg | input | 16 | Configured vendor identifier |
| did_cfg | input | 16 | Configured device identifier |
| mem_addr | output | log2(ROM_BYTES) | Image RAM byte address |
| mem_wdata | output | 8 | Image RAM write data |
| mem_we | output | 1 | Image RAM write enable |
| mem_rdata | input | 8 | Image RAM read data, one cycle after the address |
| done | output | 1 | One-cycle end-of-run pulse |
| err_code | output | 2 | 0 ok, 1 bad signature, 2 pointer out of range, 3 bad tag |

## Verification
A wrong captured header byte shows up when the run ends. It either gives a wrong `err_code` at the `done` pulse or sends writes to the wrong addresses. The whole-image comparison made at that pulse catches both. A wrong checksum correction breaks the 8-bit image sum, which is checked once the last write has landed. A sequencer stuck in a state shows as a missing `done` within a few dozen cycles of start. A stray write shows as a changed byte or a wrong write count.

// File: rtl/romid_fixup_pkg.sv
// Shared constants and types for the expansion ROM identifier patcher.
// Assumes a byte-addressed image and little-endian 16-bit fields.
package romid_fixup_pkg;

    localparam int NUM_IDS     = 2;               // vendor, device
    localparam int NREAD       = 13;              // header bytes fetched per run
    localparam int PTR_OFS     = 'h18;            // pointer word location
    localparam int CSUM_OFS    = 6;               // checksum byte location
    localparam int ID_OFS      = 4;               // first id byte inside structure
    localparam logic [15:0] SIG_WORD = 16'hAA55;
    localparam logic [31:0] TAG_WORD = 32'h52494350; // 'R','I','C','P' high to low

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RADDR,
        ST_RDATA,
        ST_CALC,
        ST_WRITE,
        ST_DONE
    } fix_state_t;

    typedef enum logic [1:0] {
        FX_OK      = 2'd0,
        FX_BAD_SIG = 2'd1,
        FX_BAD_PTR = 2'd2,
        FX_BAD_TAG = 2'd3
    } fix_err_t;

endpackage

// File: rtl/romid_csum.sv
// Checksum correction for identifier replacement.
// For every identifier that differs from its new value, adds the old bytes
// and subtracts the new bytes from the checksum, modulo 256.
// Assumes all inputs are stable when the caller samples the outputs.
module romid_csum
    import romid_fixup_pkg::*;
(
    input  logic [NUM_IDS-1:0][15:0] old_ids,
    input  logic [NUM_IDS-1:0][15:0] new_ids,
    input  logic [7:0]               old_csum,
    output logic [7:0]               fix_csum,
    output logic [NUM_IDS-1:0]       id_diff
);

    logic [NUM_IDS-1:0][7:0] delta;

    // one correction term per identifier
    for (genvar g = 0; g < NUM_IDS; g++) begin : g_term
        assign id_diff[g] = (old_ids[g] != new_ids[g]);
        assign delta[g]   = id_diff[g]
                          ? (old_ids[g][7:0] + old_ids[g][15:8]
                             - new_ids[g][7:0] - new_ids[g][15:8])
                          : 8'h00;
    end

    // accumulate all terms into the checksum byte
    always_comb begin
        fix_csum = old_csum;
        for (int i = 0; i < NUM_IDS; i++) begin
            fix_csum = fix_csum + delta[i];
        end
    end

endmodule

// File: rtl/romid_ctrl.sv
// Sequencer of the identifier patcher.
// Reads the header bytes one at a time (address cycle, then data cycle).
// Checks the signature, pointer range and tag, and stops at the first
// failure. Then writes the checksum and the differing identifier bytes.
// Assumes a RAM with one cycle of read latency and ids stable during a run.
module romid_ctrl
    import romid_fixup_pkg::*;
#(
    parameter int ROM_BYTES = 512,
    parameter int AW        = 9
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     patch_en,
    input  logic [15:0]              vid_cfg,
    input  logic [15:0]              did_cfg,
    output logic [AW-1:0]            mem_addr,
    output logic [7:0]               mem_wdata,
    output logic                     mem_we,
    input  logic [7:0]               mem_rdata,
    output logic                     done,
    output logic [1:0]               err_code,
    output logic [NUM_IDS-1:0][15:0] old_ids,
    output logic [NUM_IDS-1:0][15:0] new_ids,
    output logic [7:0]               old_csum,
    input  logic [7:0]               fix_csum,
    input  logic [NUM_IDS-1:0]       id_diff
);

    localparam int NWR = 1 + 2 * NUM_IDS;
    localparam int WW  = $clog2(NWR);
    localparam int IW  = $clog2(NREAD);
    localparam int IDW = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1;
    localparam logic [IW-1:0] IDX_SIG_LO   = IW'(0);
    localparam logic [IW-1:0] IDX_SIG_HI   = IW'(1);
    localparam logic [IW-1:0] IDX_PTR_LO   = IW'(2);
    localparam logic [IW-1:0] IDX_PTR_HI   = IW'(3);
    localparam logic [IW-1:0] IDX_TAG0     = IW'(4);
    localparam logic [IW-1:0] IDX_TAG_LAST = IW'(7);
    localparam logic [IW-1:0] IDX_LAST     = IW'(NREAD - 1);
    localparam int            IDX_ID0      = 8;

    fix_state_t              state;
    fix_err_t                err_q;
    logic [IW-1:0]           idx;
    logic [WW-1:0]           widx;
    logic [WW-1:0]           wsel;
    logic [7:0]              rd_byte [NREAD];
    logic [15:0]             ptr_q;
    logic [15:0]             ptr_w;
    logic                    ptr_too_far;
    logic                    tag_ok;
    logic [7:0]              csum_q;
    logic [NWR-1:0]          wr_mask;
    logic [NWR-1:0]          mask_w;
    logic [NUM_IDS-1:0][15:0] new_ids_q;
    logic [AW-1:0]           rd_addr;
    logic [AW-1:0]           wr_addr;
    logic [7:0]              wr_data;
    logic [15:0]             wr_id;

    assign ptr_w       = {mem_rdata, rd_byte[IDX_PTR_LO]};
    assign ptr_too_far = ({1'b0, ptr_w} + 17'd8) >= 17'(ROM_BYTES);
    assign tag_ok      = ({mem_rdata, rd_byte[6], rd_byte[5], rd_byte[IDX_TAG0]} == TAG_WORD);

    // main sequencer: fetch, validate, correct, write back, report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            err_q     <= FX_OK;
            idx       <= '0;
            widx      <= '0;
            ptr_q     <= '0;
            csum_q    <= '0;
            wr_mask   <= '0;
            new_ids_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        err_q     <= FX_OK;
                        idx       <= '0;
                        widx      <= '0;
                        new_ids_q <= {did_cfg, vid_cfg};
                        state     <= patch_en ? ST_RADDR : ST_DONE;
                    end
                end
                ST_RADDR: state <= ST_RDATA;
                ST_RDATA: begin
                    state <= ST_RADDR;
                    idx   <= idx + IW'(1);
                    if (idx == IDX_SIG_HI) begin
                        if ({mem_rdata, rd_byte[IDX_SIG_LO]} != SIG_WORD) begin
                            err_q <= FX_BAD_SIG;
                            state <= ST_DONE;
                        end
                    end else if (idx == IDX_PTR_HI) begin
                        ptr_q <= ptr_w;
                        if (ptr_too_far) begin
                            err_q <= FX_BAD_PTR;
                            state <= ST_DONE;
                        end
                    end else if (idx == IDX_TAG_LAST) begin
                        if (!tag_ok) begin
                            err_q <= FX_BAD_TAG;
                            state <= ST_DONE;
                        end
                    end else if (idx == IDX_LAST) begin
                        state <= ST_CALC;
                    end
                end
                ST_CALC: begin
                    csum_q  <= fix_csum;
                    wr_mask <= mask_w;
                    state   <= ST_WRITE;
                end
                ST_WRITE: begin
                    widx <= widx + WW'(1);
                    if (widx == WW'(NWR - 1)) state <= ST_DONE;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // capture each fetched header byte in its slot
    always_ff @(posedge clk) begin
        if (state == ST_RDATA) rd_byte[idx] <= mem_rdata;
    end

    // present the stored identifiers and checksum to the correction logic
    for (genvar g = 0; g < NUM_IDS; g++) begin : g_old
        assign old_ids[g] = {rd_byte[IDX_ID0 + 2*g + 1], rd_byte[IDX_ID0 + 2*g]};
    end
    assign old_csum = rd_byte[IDX_LAST];
    assign new_ids  = new_ids_q;

    // write mask: checksum if anything differs, id bytes per differing id
    always_comb begin
        mask_w    = '0;
        mask_w[0] = |id_diff;
        for (int g = 0; g < NUM_IDS; g++) begin
            mask_w[1 + 2*g] = id_diff[g];
            mask_w[2 + 2*g] = id_diff[g];
        end
    end

    // read address for the current fetch index
    always_comb begin
        case (idx)
            IDX_SIG_LO: rd_addr = '0;
            IDX_SIG_HI: rd_addr = AW'(1);
            IDX_PTR_LO: rd_addr = AW'(PTR_OFS);
            IDX_PTR_HI: rd_addr = AW'(PTR_OFS + 1);
            IDX_LAST:   rd_addr = AW'(CSUM_OFS);
            default:    rd_addr = ptr_q[AW-1:0] + AW'(idx) - AW'(IDX_TAG0);
        endcase
    end

    // write address and data for the current write slot
    always_comb begin
        wsel    = widx - WW'(1);
        wr_id   = new_ids_q[wsel[IDW:1]];
        wr_data = (widx == '0) ? csum_q : (wsel[0] ? wr_id[15:8] : wr_id[7:0]);
        wr_addr = (widx == '0) ? AW'(CSUM_OFS)
                               : ptr_q[AW-1:0] + AW'(ID_OFS) + AW'(wsel);
    end

    // memory port drive by phase
    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        mem_we    = 1'b0;
        case (state)
            ST_RADDR, ST_RDATA: mem_addr = rd_addr;
            ST_WRITE: begin
                mem_addr  = wr_addr;
                mem_wdata = wr_data;
                mem_we    = wr_mask[widx];
            end
            default: ;
        endcase
    end

    assign done     = (state == ST_DONE);
    assign err_code = err_q;

    // checker state: a write happened during the current run
    logic wr_seen;
    always_ff @(posedge clk) begin
        if (!rst_n)                          wr_seen <= 1'b0;
        else if (state == ST_IDLE && start)  wr_seen <= 1'b0;
        else if (mem_we)                     wr_seen <= 1'b1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!done && !mem_we));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

    // R2 R3 R4
    err_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code != 2'd0) |-> !wr_seen);

endmodule

// File: rtl/romid_fixup.sv
// Top of the expansion ROM identifier patcher.
// Joins the sequencer and the checksum correction logic.
// Assumes ROM_BYTES is a power of two between 32 and 65536.
module romid_fixup
    import romid_fixup_pkg::*;
#(
    parameter int ROM_BYTES = 512,
    localparam int AW       = $clog2(ROM_BYTES)
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          patch_en,
    input  logic [15:0]   vid_cfg,
    input  logic [15:0]   did_cfg,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          mem_we,
    input  logic [7:0]    mem_rdata,
    output logic          done,
    output logic [1:0]    err_code
);

    logic [NUM_IDS-1:0][15:0] old_ids;
    logic [NUM_IDS-1:0][15:0] new_ids;
    logic [7:0]               old_csum;
    logic [7:0]               fix_csum;
    logic [NUM_IDS-1:0]       id_diff;

    romid_ctrl #(.ROM_BYTES(ROM_BYTES), .AW(AW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .patch_en  (patch_en),
        .vid_cfg   (vid_cfg),
        .did_cfg   (did_cfg),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .done      (done),
        .err_code  (err_code),
        .old_ids   (old_ids),
        .new_ids   (new_ids),
        .old_csum  (old_csum),
        .fix_csum  (fix_csum),
        .id_diff   (id_diff)
    );

    romid_csum u_csum (
        .old_ids  (old_ids),
        .new_ids  (new_ids),
        .old_csum (old_csum),
        .fix_csum (fix_csum),
        .id_diff  (id_diff)
    );

    // byte sums of the field set before and after correction
    logic [7:0] sum_before;
    logic [7:0] sum_after;
    always_comb begin
        sum_before = old_csum;
        sum_after  = fix_csum;
        for (int g = 0; g < NUM_IDS; g++) begin
            sum_before = sum_before + old_ids[g][7:0] + old_ids[g][15:8];
            sum_after  = sum_after + (id_diff[g] ? (new_ids[g][7:0] + new_ids[g][15:8])
                                                 : (old_ids[g][7:0] + old_ids[g][15:8]));
        end
    end

    // R6
    sum_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sum_before == sum_after);

endmodule

// File: tb/romid_fixup_test.sv
// Scoreboard bench for the identifier patcher: the driver builds an image,
// computes the expected outcome and queues it; the monitor compares at done.
module romid_fixup_test;

    localparam int ROM_BYTES = 512;
    localparam int AW        = $clog2(ROM_BYTES);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          patch_en = 1'b0;
    logic [15:0]   vid_cfg = '0;
    logic [15:0]   did_cfg = '0;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          mem_we;
    logic [7:0]    mem_rdata;
    logic          done;
    logic [1:0]    err_code;

    logic [7:0] img     [ROM_BYTES];
    logic [7:0] exp_img [ROM_BYTES];

    typedef struct {
        string      req;
        logic [1:0] err;
        int         nwr;
        bit         patched;
        logic [7:0] sum0;
    } item_t;

    item_t sb_q[$];
    int checks   = 0;
    int errors   = 0;
    int wr_count = 0;

    always #4 clk = ~clk;

    romid_fixup #(.ROM_BYTES(ROM_BYTES)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .patch_en(patch_en),
        .vid_cfg(vid_cfg), .did_cfg(did_cfg),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .done(done), .err_code(err_code)
    );

    // image RAM with one cycle of read latency
    always @(posedge clk) begin
        if (mem_we) img[mem_addr] <= mem_wdata;
        mem_rdata <= img[mem_addr];
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] img_sum();
        logic [7:0] s = 8'h00;
        for (int i = 0; i < ROM_BYTES; i++) s = s + img[i];
        return s;
    endfunction

    // count writes away from the clock edge
    always @(negedge clk) if (mem_we) wr_count++;

    task automatic score();
        item_t it;
        int    mism = 0;
        if (sb_q.size() == 0) begin
            chk(1'b0, "R9", "done without a run", 1, 0);
            return;
        end
        it = sb_q.pop_front();
        chk(err_code == it.err, it.req, "error code", int'(err_code), int'(it.err));
        chk(wr_count == it.nwr, it.req, "write count", wr_count, it.nwr);
        for (int i = 0; i < ROM_BYTES; i++) if (img[i] !== exp_img[i]) mism++;
        chk(mism == 0, "R10", "bytes differing from expected image", mism, 0);
        if (it.patched)
            chk(img_sum() == it.sum0, "R6", "image byte sum", int'(img_sum()), int'(it.sum0));
    endtask

    // monitor: compare the oldest expectation at each done pulse
    always @(negedge clk) if (rst_n && done) score();

    task automatic build(input int p, input bit sig_ok, input bit tag_ok,
                         input logic [15:0] ov, input logic [15:0] od,
                         input logic [7:0] cs, input int seed);
        for (int i = 0; i < ROM_BYTES; i++) img[i] = 8'(i * 37 + seed);
        img[0]    = 8'h55;
        img[1]    = sig_ok ? 8'hAA : 8'hAB;
        img['h18] = p[7:0];
        img['h19] = p[15:8];
        img[6]    = cs;
        if (p + 7 < ROM_BYTES) begin
            img[p]     = 8'h50;
            img[p + 1] = 8'h43;
            img[p + 2] = 8'h49;
            img[p + 3] = tag_ok ? 8'h52 : 8'h58;
            img[p + 4] = ov[7:0];
            img[p + 5] = ov[15:8];
            img[p + 6] = od[7:0];
            img[p + 7] = od[15:8];
        end
    endtask

    task automatic run_case(input string req, input bit pe,
                            input logic [15:0] v, input logic [15:0] d);
        item_t      it;
        int         p;
        int         n = 0;
        int         t = 0;
        logic [7:0] c;
        logic [15:0] o;
        for (int i = 0; i < ROM_BYTES; i++) exp_img[i] = img[i];
        it.req = req; it.err = 2'd0; it.nwr = 0; it.patched = 1'b0; it.sum0 = img_sum();
        if (pe) begin
            p = {img['h19], img['h18]};
            if ({img[1], img[0]} != 16'hAA55) it.err = 2'd1;
            else if (p + 8 >= ROM_BYTES) it.err = 2'd2;
            else if (img[p] != 8'h50 || img[p+1] != 8'h43 || img[p+2] != 8'h49 || img[p+3] != 8'h52)
                it.err = 2'd3;
            else begin
                c = img[6];
                o = {img[p+5], img[p+4]};
                if (o != v) begin
                    c = c + o[7:0] + o[15:8] - v[7:0] - v[15:8];
                    exp_img[p+4] = v[7:0]; exp_img[p+5] = v[15:8]; n++;
                end
                o = {img[p+7], img[p+6]};
                if (o != d) begin
                    c = c + o[7:0] + o[15:8] - d[7:0] - d[15:8];
                    exp_img[p+6] = d[7:0]; exp_img[p+7] = d[15:8]; n++;
                end
                if (n > 0) begin
                    exp_img[6] = c; it.nwr = 1 + 2 * n; it.patched = 1'b1;
                end
            end
        end
        sb_q.push_back(it);
        wr_count = 0;
        vid_cfg  = v;
        did_cfg  = d;
        patch_en = pe;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && t < 400) begin
            @(negedge clk);
            t++;
        end
        if (!done) begin
            chk(1'b0, "R9", "no done before timeout", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
        @(negedge clk);
        chk(!done, "R9", "done lasts one cycle", int'(done), 0);
        repeat (2) @(negedge clk);
        chk(err_code == it.err, "R9", "error code held", int'(err_code), int'(it.err));
    endtask

    initial begin
        #(8 * 200000);
        chk(1'b0, "R9", "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < ROM_BYTES; i++) img[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(!done, "R1", "done in reset", int'(done), 0);
        chk(!mem_we, "R1", "write enable in reset", int'(mem_we), 0);
        chk(err_code == 2'd0, "R1", "error code in reset", int'(err_code), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !mem_we, "R1", "quiet after reset", int'(done | mem_we), 0);

        build('h40, 1, 1, 16'h8086, 16'h100E, 8'h3C, 1);
        run_case("R5", 1'b1, 16'h1AF4, 16'h1000);          // both differ
        build('h80, 1, 1, 16'h8086, 16'h100E, 8'hF0, 2);
        run_case("R5", 1'b1, 16'h1234, 16'h100E);          // vendor only
        build('h60, 1, 1, 16'h1AF4, 16'h00FF, 8'h02, 3);
        run_case("R6", 1'b1, 16'h1AF4, 16'hFFFF);          // device only, wraps
        build('h44, 1, 1, 16'hABCD, 16'h4321, 8'h77, 4);
        run_case("R7", 1'b1, 16'hABCD, 16'h4321);          // nothing differs
        build('h40, 0, 1, 16'h8086, 16'h100E, 8'h3C, 5);
        run_case("R2", 1'b1, 16'h1AF4, 16'h1000);          // bad signature
        build(ROM_BYTES - 8, 1, 1, 16'h8086, 16'h100E, 8'h3C, 6);
        run_case("R3", 1'b1, 16'h1AF4, 16'h1000);          // pointer one past limit
        build(ROM_BYTES - 9, 1, 1, 16'h8086, 16'h100E, 8'h11, 7);
        run_case("R3", 1'b1, 16'hFFFF, 16'h0001);          // pointer at limit
        build('hFFF0, 1, 1, 16'h0, 16'h0, 8'h00, 8);
        run_case("R3", 1'b1, 16'h1111, 16'h2222);          // far pointer
        build('h40, 1, 0, 16'h8086, 16'h100E, 8'h3C, 9);
        run_case("R4", 1'b1, 16'h1AF4, 16'h1000);          // bad tag
        build('h40, 1, 1, 16'h8086, 16'h100E, 8'h3C, 10);
        run_case("R8", 1'b0, 16'h1AF4, 16'h1000);          // patching off
        build('h20, 1, 1, 16'h0000, 16'h0000, 8'hFF, 11);
        run_case("R6", 1'b1, 16'hFFFF, 16'hFFFF);          // large correction

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule